// File: doc/BRIEF.md
# Network Controller Status and Interrupt Register

This block holds the main control/status word of a network controller and the per-source interrupt mask word next to it. The status word carries the run-control bits (initialise, start, stop, transmit poll demand), the run indicators for the receive and transmit sides, seven event flags raised by single-cycle pulses from the datapath, a derived error summary, a derived interrupt summary and an interrupt enable. The block drives a level interrupt output from the summary and the enable.

Software reads the status word to find pending events. It clears them by writing ones to the flag positions, so a read followed by a write-back of the same value clears everything that was pending. The mask word chooses which events may raise the interrupt summary. The run-control bits are commands: a stop request always wins, a start request brings both the receive and transmit sides up, and an initialise request remains pending until the datapath reports that initialisation has completed.

Top module: `nic_csr_irq`

## Requirements
- R1: After reset the status word reads 0x0004 (stop set, every other bit 0), the mask word reads 0x0000, `runStop` is 1 and `irq` is 0.
- R2: An event pulse sets its flag, and the flag reads 1 from the cycle after the pulse. The flag positions in the status word are: init done bit 8, transmit done bit 9, receive done bit 10, memory error bit 11, missed frame bit 12, collision error bit 13, babble bit 14.
- R3: A status write with a 1 in a flag position clears that flag, and a 0 leaves it unchanged. If an event pulse arrives in the same cycle as the clear, the pulse wins and the flag stays set.
- R4: Bit 15 (error summary) reads as the OR of the flags at bits 14, 13, 12 and 11. Writes to bit 15 are ignored.
- R5: Bit 7 (interrupt summary) reads 1 when any of the flags at bits 14, 12, 11, 10, 9 or 8 is set and its mask bit at the same position in the mask word is 0. The collision error flag never sets bit 7. Writes to bit 7 are ignored.
- R6: Every status write loads bit 6 (interrupt enable) from the written data. `irq` is 1 exactly when bit 7 and bit 6 are both 1.
- R7: A status write with bit 1 = 1, bit 0 = 0 and bit 2 = 0 sets start (bit 1), receive-on (bit 5) and transmit-on (bit 4), and clears stop (bit 2).
- R8: A status write with bit 2 = 1 sets stop and clears start, initialise, receive-on, transmit-on and poll demand, whatever the other written bits are.
- R9: A status write with bit 0 = 1 and bit 2 = 0 sets initialise (bit 0) and clears stop. It does not start the controller, even if bit 1 is also 1. The init-done pulse clears initialise.
- R10: A status write with bit 3 = 1 while started sets poll demand (bit 3, `pollReq`) for exactly one cycle. While not started the write is ignored.
- R11: Writing 0 to a run-control bit leaves it unchanged. The mask word keeps only bits 14, 12, 11, 10, 9 and 8, and all of its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for the selected word |
| regSel | input | 1 | Word select: 0 status word, 1 mask word |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data of the selected word (combinational) |
| evInitDone | input | 1 | Pulse: initialisation completed |
| evTxDone | input | 1 | Pulse: frame transmitted |
| evRxDone | input | 1 | Pulse: frame received |
| evMemErr | input | 1 | Pulse: bus access timed out |
| evMissed | input | 1 | Pulse: incoming frame lost |
| evCollErr | input | 1 | Pulse: collision detection failed |
| evBabble | input | 1 | Pulse: transmitter ran too long |
| runInit | output | 1 | Initialise request level |
| runStart | output | 1 | Controller started |
| runStop | output | 1 | Controller stopped |
| rxOn | output | 1 | Receive side enabled |
| txOn | output | 1 | Transmit side enabled |
| pollReq | output | 1 | One-cycle transmit ring poll request |
| irq | output | 1 | Interrupt output, active high |

## Verification
Events are raised singly and in pairs. A lone collision error separates the error summary from the interrupt summary, and the babble and receive pair shows both summaries together. The mask and enable are swept one at a time over a pending receive flag, which shows whether the summary bit, the enable or the mask is what holds back the output. The run-control bits are tried with stop alone, stop together with start, initialise together with start, and poll demand while running and while stopped, which confirms the priority order. A clear and an event pulse are also made to collide in one cycle.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int WORD_W   = 16;
  localparam int N_EVT    = 7;
  localparam int FLAG_LSB = 8;
  localparam int ERR_BIT  = 15;
  localparam int INTR_BIT = 7;
  localparam int IENA_BIT = 6;
  localparam int RXON_BIT = 5;
  localparam int TXON_BIT = 4;
  localparam int TDMD_BIT = 3;
  localparam int STOP_BIT = 2;
  localparam int STRT_BIT = 1;
  localparam int INIT_BIT = 0;

  // event index inside the flag vector (flag i sits at word bit FLAG_LSB+i)
  localparam int EV_IDON = 0;
  localparam int EV_TINT = 1;
  localparam int EV_RINT = 2;
  localparam int EV_MERR = 3;
  localparam int EV_MISS = 4;
  localparam int EV_CERR = 5;
  localparam int EV_BABL = 6;

  // events that may raise the interrupt summary and own a mask bit
  localparam logic [N_EVT-1:0] MASKABLE = 7'b101_1111;
  // events folded into the error summary
  localparam logic [N_EVT-1:0] ERR_SET  = 7'b111_1000;

  // writable bits of the status word (summaries are read-only)
  localparam logic [WORD_W-1:0] STATUS_WR_MASK = 16'h7F4F;

  typedef struct packed {
    logic             wrStatus;
    logic             wrMask;
    logic             doStop;
    logic             doStart;
    logic             doInit;
    logic             doDemand;
    logic             ienaVal;
    logic [N_EVT-1:0] clrFlags;
    logic [N_EVT-1:0] maskVal;
  } csr_strobe_t;
endpackage

// File: rtl/nic_csr_ctl.sv
module nic_csr_ctl
  import nic_csr_pkg::*;
(
  input  logic              busWr,
  input  logic              regSel,
  input  logic [WORD_W-1:0] busWdata,
  input  logic              started,
  output csr_strobe_t       strobe
);
  logic [WORD_W-1:0] wd;
  logic wrS;
  logic wrM;

  always_comb begin
    wd  = busWdata & STATUS_WR_MASK;
    wrS = busWr && !regSel;
    wrM = busWr && regSel;

    strobe.wrStatus = wrS;
    strobe.wrMask   = wrM;
    // stop beats every other command in the same write
    strobe.doStop   = wrS && wd[STOP_BIT];
    strobe.doStart  = wrS && wd[STRT_BIT] && !wd[INIT_BIT] && !wd[STOP_BIT];
    strobe.doInit   = wrS && wd[INIT_BIT] && !wd[STOP_BIT];
    strobe.doDemand = wrS && wd[TDMD_BIT] && !wd[STOP_BIT] && started;
    strobe.ienaVal  = wd[IENA_BIT];
    strobe.clrFlags = wrS ? wd[FLAG_LSB +: N_EVT] : '0;
    strobe.maskVal  = wd[FLAG_LSB +: N_EVT] & MASKABLE;
  end
endmodule

// File: rtl/nic_csr_dp.sv
module nic_csr_dp
  import nic_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csr_strobe_t       strobe,
  input  logic [N_EVT-1:0]  evSet,
  output logic [WORD_W-1:0] statusWord,
  output logic [WORD_W-1:0] maskWord,
  output logic              started,
  output logic              irq,
  output logic              initQ,
  output logic              stopQ,
  output logic              rxOnQ,
  output logic              txOnQ,
  output logic              tdmdQ
);
  logic [N_EVT-1:0] flagQ;
  logic [N_EVT-1:0] maskQ;
  logic             ienaQ;
  logic             strtQ;
  logic             errSum;
  logic             intrSum;

  // one flag register per event source
  for (genvar i = 0; i < N_EVT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) flagQ[i] <= 1'b0;
      else       flagQ[i] <= evSet[i] | (flagQ[i] & ~strobe.clrFlags[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      ienaQ <= 1'b0;
    end else begin
      if (strobe.wrMask)   maskQ <= strobe.maskVal;
      if (strobe.wrStatus) ienaQ <= strobe.ienaVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopQ <= 1'b1;
      strtQ <= 1'b0;
      initQ <= 1'b0;
      rxOnQ <= 1'b0;
      txOnQ <= 1'b0;
      tdmdQ <= 1'b0;
    end else if (strobe.doStop) begin
      stopQ <= 1'b1;
      strtQ <= 1'b0;
      initQ <= 1'b0;
      rxOnQ <= 1'b0;
      txOnQ <= 1'b0;
      tdmdQ <= 1'b0;
    end else begin
      if (strobe.doStart) begin
        strtQ <= 1'b1;
        rxOnQ <= 1'b1;
        txOnQ <= 1'b1;
      end
      if (strobe.doStart || strobe.doInit) stopQ <= 1'b0;
      if (strobe.doInit)            initQ <= 1'b1;
      else if (evSet[EV_IDON])      initQ <= 1'b0;
      tdmdQ <= strobe.doDemand && !tdmdQ;
    end
  end

  always_comb begin
    errSum  = |(flagQ & ERR_SET);
    intrSum = |(flagQ & ~maskQ & MASKABLE);
    irq     = intrSum && ienaQ;
    started = strtQ;

    statusWord                       = '0;
    statusWord[ERR_BIT]              = errSum;
    statusWord[FLAG_LSB +: N_EVT]    = flagQ;
    statusWord[INTR_BIT]             = intrSum;
    statusWord[IENA_BIT]             = ienaQ;
    statusWord[RXON_BIT]             = rxOnQ;
    statusWord[TXON_BIT]             = txOnQ;
    statusWord[TDMD_BIT]             = tdmdQ;
    statusWord[STOP_BIT]             = stopQ;
    statusWord[STRT_BIT]             = strtQ;
    statusWord[INIT_BIT]             = initQ;

    maskWord                         = '0;
    maskWord[FLAG_LSB +: N_EVT]      = maskQ;
  end

  // R2/R3: a pulse always leaves its flag set on the next cycle
  a_r3_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (evSet != '0) |=> ((flagQ & $past(evSet)) == $past(evSet)));

  // R8: stop request drops every run level
  a_r8_stop_clears_run: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doStop |=> (stopQ && !strtQ && !initQ && !rxOnQ && !txOnQ && !tdmdQ));

  // R10: poll demand never lasts more than one cycle
  a_r10_demand_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    tdmdQ |=> !tdmdQ);

  // R7: stopped and started are never both set
  a_r7_stop_start_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stopQ, strtQ}));

  // R7: a start request leaves the controller running
  a_r7_start_runs: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doStart |=> (strtQ && rxOnQ && txOnQ && !stopQ));
endmodule

// File: rtl/nic_csr_irq.sv
module nic_csr_irq
  import nic_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              regSel,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  logic              evInitDone,
  input  logic              evTxDone,
  input  logic              evRxDone,
  input  logic              evMemErr,
  input  logic              evMissed,
  input  logic              evCollErr,
  input  logic              evBabble,
  output logic              runInit,
  output logic              runStart,
  output logic              runStop,
  output logic              rxOn,
  output logic              txOn,
  output logic              pollReq,
  output logic              irq
);
  csr_strobe_t       strobe;
  logic [N_EVT-1:0]  evSet;
  logic [WORD_W-1:0] statusWord;
  logic [WORD_W-1:0] maskWord;
  logic              started;

  always_comb begin
    evSet          = '0;
    evSet[EV_IDON] = evInitDone;
    evSet[EV_TINT] = evTxDone;
    evSet[EV_RINT] = evRxDone;
    evSet[EV_MERR] = evMemErr;
    evSet[EV_MISS] = evMissed;
    evSet[EV_CERR] = evCollErr;
    evSet[EV_BABL] = evBabble;
  end

  nic_csr_ctl u_ctl (
    .busWr    (busWr),
    .regSel   (regSel),
    .busWdata (busWdata),
    .started  (started),
    .strobe   (strobe)
  );

  nic_csr_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .evSet      (evSet),
    .statusWord (statusWord),
    .maskWord   (maskWord),
    .started    (started),
    .irq        (irq),
    .initQ      (runInit),
    .stopQ      (runStop),
    .rxOnQ      (rxOn),
    .txOnQ      (txOn),
    .tdmdQ      (pollReq)
  );

  assign runStart = started;
  assign busRdata = regSel ? maskWord : statusWord;

  // R6: the output only rises when the status word shows summary and enable
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusWord[INTR_BIT] && statusWord[IENA_BIT]));
endmodule

// File: tb/test_nic_csr_irq.sv
module test_nic_csr_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        regSel = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [6:0]  evs = '0;   // idx: 0 idon,1 tint,2 rint,3 merr,4 miss,5 cerr,6 babl
  logic runInit, runStart, runStop, rxOn, txOn, pollReq, irq;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nic_csr_irq i_nic_csr_irq (
    .clk(clk), .rstN(rstN), .busWr(busWr), .regSel(regSel),
    .busWdata(busWdata), .busRdata(busRdata),
    .evInitDone(evs[0]), .evTxDone(evs[1]), .evRxDone(evs[2]),
    .evMemErr(evs[3]), .evMissed(evs[4]), .evCollErr(evs[5]),
    .evBabble(evs[6]),
    .runInit(runInit), .runStart(runStart), .runStop(runStop),
    .rxOn(rxOn), .txOn(txOn), .pollReq(pollReq), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    busWr = 1'b1; regSel = sel; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    regSel = sel;
    #1;
    v = busRdata;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk);
    evs = e;
    @(negedge clk);
    evs = '0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(1'b0, v); chk("R1 status", v, 16'h0004);
    rd(1'b1, v); chk("R1 mask", v, 16'h0000);
    chk("R1 stop pin", {15'd0, runStop}, 16'd1);
    chk("R1 irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_events;
    logic [15:0] v;
    pulse(7'b000_0100);                       // receive done
    rd(1'b0, v); chk("R2 rint sets bit10 + R5 intr", v, 16'h0484);
    pulse(7'b100_0000);                       // babble
    rd(1'b0, v); chk("R4 babble err summary", v, 16'hC484);
    wr(1'b0, 16'h0000);
    rd(1'b0, v); chk("R3 write zero keeps flags", v, 16'hC484);
    wr(1'b0, 16'hC484);                       // read-back write clears all
    rd(1'b0, v); chk("R3 writeback clears", v, 16'h0004);
    pulse(7'b010_0000);                       // collision error
    rd(1'b0, v); chk("R4 R5 cerr sets err not intr", v, 16'hA004);
    wr(1'b0, 16'h2004);
    pulse(7'b000_1000);                       // memory error
    rd(1'b0, v); chk("R2 merr bit11", v, 16'h8884);
    wr(1'b0, 16'h0804);
    pulse(7'b001_0001);                       // missed + init done
    rd(1'b0, v); chk("R2 miss bit12 idon bit8", v, 16'h9184);
    wr(1'b0, 16'h1104);
    rd(1'b0, v); chk("R3 cleared", v, 16'h0004);
  endtask

  task automatic t_mask_irq;
    logic [15:0] v;
    wr(1'b1, 16'h0400);
    rd(1'b1, v); chk("R11 mask readback", v, 16'h0400);
    pulse(7'b000_0100);
    rd(1'b0, v); chk("R5 masked rint no intr", v, 16'h0404);
    wr(1'b0, 16'h0044);                       // enable, keep stop
    rd(1'b0, v); chk("R6 iena loaded", v, 16'h0444);
    chk("R6 irq off while masked", {15'd0, irq}, 16'd0);
    wr(1'b1, 16'h0000);
    rd(1'b0, v); chk("R5 unmasked intr", v, 16'h04C4);
    chk("R6 irq on", {15'd0, irq}, 16'd1);
    wr(1'b0, 16'h0004);
    chk("R6 irq off when iena cleared", {15'd0, irq}, 16'd0);
    wr(1'b1, 16'hFFFF);
    rd(1'b1, v); chk("R11 mask reserved bits", v, 16'h5F00);
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'h0404);
    // clear and set collide: pulse wins
    pulse(7'b000_0010);
    @(negedge clk);
    busWr = 1'b1; regSel = 1'b0; busWdata = 16'h0204; evs = 7'b000_0010;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0; evs = '0;
    rd(1'b0, v); chk("R3 set wins over clear", v, 16'h0284);
    wr(1'b0, 16'h0204);
    rd(1'b0, v); chk("R3 tint cleared", v, 16'h0004);
  endtask

  task automatic t_run;
    logic [15:0] v;
    wr(1'b0, 16'h0002);
    rd(1'b0, v); chk("R7 start", v, 16'h0032);
    chk("R7 pins", {10'd0, runStart, runStop, rxOn, txOn, runInit, pollReq},
        16'b10_1100);
    wr(1'b0, 16'h0008);
    chk("R10 demand high", {15'd0, pollReq}, 16'd1);
    @(negedge clk);
    chk("R10 demand self clears", {15'd0, pollReq}, 16'd0);
    wr(1'b0, 16'h0000);
    rd(1'b0, v); chk("R11 zero write keeps run", v, 16'h0032);
    wr(1'b0, 16'h0006);
    rd(1'b0, v); chk("R8 stop wins over start", v, 16'h0004);
    wr(1'b0, 16'h0008);
    chk("R10 demand ignored when stopped", {15'd0, pollReq}, 16'd0);
    rd(1'b0, v); chk("R10 status stopped", v, 16'h0004);
  endtask

  task automatic t_init;
    logic [15:0] v;
    wr(1'b0, 16'h0001);
    rd(1'b0, v); chk("R9 init set", v, 16'h0001);
    wr(1'b0, 16'h0003);
    rd(1'b0, v); chk("R9 init+start does not start", v, 16'h0001);
    pulse(7'b000_0001);
    rd(1'b0, v); chk("R9 init done clears init", v, 16'h0180);
    wr(1'b0, 16'h0001);
    wr(1'b0, 16'h0005);
    rd(1'b0, v); chk("R8 stop clears init", v, 16'h0184);
    wr(1'b0, 16'h0104);
    rd(1'b0, v); chk("R3 final clear", v, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_mask_irq();
    t_run();
    t_init();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule